// File: doc/BRIEF.md
# Queue Watermark Interrupt Controller

This block tracks the occupancy of four queues that sit beside a two-wire serial bus engine. The queues are the controller command queue, the controller receive queue, the target transmit queue and the target acquisition queue. Each queue is modelled as an occupancy counter driven by push and pop strobes. The block reports each fill level, a full flag and an empty flag for every queue. It also turns level crossings and dropped pushes into interrupt state.

The receive queue and the command queue each have a programmable watermark, picked from a small table by an encoded select field. The receive interrupt marks a rise above its watermark. The command interrupt marks a fall below its watermark. Threshold and overflow events are held in sticky bits until software writes one to clear them. The acquisition full interrupt is a live level. Each queue also has a one-cycle flush strobe that empties it. The flush strobe holds no state, so a read of it returns zero.

Top module: `queue_watermark_irq`

## Requirements
- R1: Queue index q is 0 for command, 1 for receive, 2 for target transmit and 3 for acquisition. Its level is reported on level_o[q*LVL_W +: LVL_W]. A push raises the level by one unless the queue is full. A pop lowers it by one unless the queue is empty. Both effects apply in the same cycle, and the level never exceeds DEPTH (64 by default).
- R2: full_o[q] is 1 exactly when level q equals DEPTH, and empty_o[q] is 1 exactly when level q is 0.
- R3: A flush_i[q] strobe sets level q to 0 at the next edge. The flush overrides any push or pop in the same cycle and raises no overflow. The flush acts only in the cycle it is asserted.
- R4: The receive select codes 0, 1, 2, 3 and 4 give watermarks of 1, 4, 8, 16 and 30 entries. The unused codes 5, 6 and 7 give 30.
- R5: irq_o[1] is set in the cycle when the receive level moves from at most its watermark to above it.
- R6: irq_o[0] is set in the cycle when the command level moves from at least its watermark to below it. The command select codes 0, 1, 2 and 3 give watermarks of 1, 4, 8 and 16 entries.
- R7: irq_o[2], irq_o[3] and irq_o[4] are set when a push, with no flush in the same cycle, hits a full command, receive or target transmit queue. The push is dropped.
- R8: irq_o[5] equals the acquisition full flag. irq_clr_i has no effect on it.
- R9: irq_o[4:0] hold their value until the matching irq_clr_i bit is pulsed. A set event in the same cycle as a clear wins.
- R10: After reset, every level is 0, empty_o is all ones, full_o is all zeros and irq_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 4 | Push strobe per queue |
| pop_i | input | 4 | Pop strobe per queue |
| flush_i | input | 4 | Write-one flush strobe per queue |
| rx_lvl_sel_i | input | 3 | Receive watermark code |
| cmd_lvl_sel_i | input | 2 | Command watermark code |
| irq_clr_i | input | 5 | Write-one clear of the sticky interrupt bits |
| level_o | output | 4*LVL_W | Packed fill levels |
| full_o | output | 4 | Full flag per queue |
| empty_o | output | 4 | Empty flag per queue |
| irq_o | output | 6 | Interrupt state |

## Verification
The hardest situations to reach are a push landing on a full queue and a command level dropping under a 16-entry watermark. Both need long runs in one direction on the strobes. The stimulus therefore works in phases that favour pushes and then favour pops. Each phase uses one fixed pair of select codes, so the queues swing between empty and full and cross every watermark, the unused receive codes included. Rare flushes and clears are mixed in, so that each sometimes coincides with a set event or with a full queue.

// File: rtl/qlw_pkg.sv
package qlw_pkg;

    localparam int NQ      = 4;
    localparam int Q_CMD   = 0;
    localparam int Q_RCV   = 1;
    localparam int Q_TTX   = 2;
    localparam int Q_ACQ   = 3;
    localparam int NSTICKY = 5;
    localparam int NIRQ    = 6;

    // sticky interrupt bit positions
    localparam int I_CMD_LOW = 0;
    localparam int I_RCV_HI  = 1;
    localparam int I_CMD_OVF = 2;
    localparam int I_RCV_OVF = 3;
    localparam int I_TTX_OVF = 4;

    function automatic int unsigned rcv_mark(input logic [2:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 4;
            3'd2:    return 8;
            3'd3:    return 16;
            default: return 30;
        endcase
    endfunction

    function automatic int unsigned cmd_mark(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/qlw_level_ctr.sv
module qlw_level_ctr #(
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             flush_i,
    output logic [LVL_W-1:0] level_o,
    output logic [LVL_W-1:0] level_nxt_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             ovf_o
);

    localparam logic [LVL_W-1:0] TOP = LVL_W'(DEPTH);

    typedef struct packed {
        logic [LVL_W-1:0] level;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic full, empty, push_ok, pop_ok;

    always_comb begin
        ctr_d   = ctr_q;
        full    = (ctr_q.level == TOP);
        empty   = (ctr_q.level == '0);
        push_ok = push_i && !full;
        pop_ok  = pop_i && !empty;
        if (flush_i) begin
            ctr_d.level = '0;
        end else begin
            ctr_d.level = ctr_q.level + LVL_W'(push_ok) - LVL_W'(pop_ok);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctr_q <= '0;
        else         ctr_q <= ctr_d;
    end

    assign level_o     = ctr_q.level;
    assign level_nxt_o = ctr_d.level;
    assign full_o      = full;
    assign empty_o     = empty;
    assign ovf_o       = push_i && full && !flush_i;

    a_r1_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        level_o <= TOP);
    a_r3_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> empty_o);
    a_r7_drop_at_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && full_o && !pop_i && !flush_i) |=> full_o);

endmodule

// File: rtl/qlw_irq_reg.sv
module qlw_irq_reg #(
    parameter int W = 5
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] state_o
);

    typedef struct packed {
        logic [W-1:0] bits;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d      = irq_q;
        irq_d.bits = (irq_q.bits & ~clr_i) | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) irq_q <= '0;
        else         irq_q <= irq_d;
    end

    assign state_o = irq_q.bits;

    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(state_o & ~clr_i)) |=> ((state_o & $past(state_o & ~clr_i)) == $past(state_o & ~clr_i)));
    a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|set_i) |=> ((state_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/queue_watermark_irq.sv
module queue_watermark_irq
    import qlw_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [3:0]            push_i,
    input  logic [3:0]            pop_i,
    input  logic [3:0]            flush_i,
    input  logic [2:0]            rx_lvl_sel_i,
    input  logic [1:0]            cmd_lvl_sel_i,
    input  logic [4:0]            irq_clr_i,
    output logic [4*LVL_W-1:0]    level_o,
    output logic [3:0]            full_o,
    output logic [3:0]            empty_o,
    output logic [5:0]            irq_o
);

    logic [LVL_W-1:0]   lvl_q   [NQ];
    logic [LVL_W-1:0]   lvl_n   [NQ];
    logic [NQ-1:0]      ovf;
    logic [LVL_W-1:0]   rcv_thr, cmd_thr;
    logic [NSTICKY-1:0] set_vec, sticky;

    for (genvar q = 0; q < NQ; q++) begin : g_q
        qlw_level_ctr #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_ctr (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .push_i     (push_i[q]),
            .pop_i      (pop_i[q]),
            .flush_i    (flush_i[q]),
            .level_o    (lvl_q[q]),
            .level_nxt_o(lvl_n[q]),
            .full_o     (full_o[q]),
            .empty_o    (empty_o[q]),
            .ovf_o      (ovf[q])
        );
        assign level_o[q*LVL_W +: LVL_W] = lvl_q[q];
    end

    // crossing detection compares present and next level against one watermark
    always_comb begin
        rcv_thr = LVL_W'(rcv_mark(rx_lvl_sel_i));
        cmd_thr = LVL_W'(cmd_mark(cmd_lvl_sel_i));
        set_vec = '0;
        set_vec[I_RCV_HI]  = (lvl_n[Q_RCV] > rcv_thr) && !(lvl_q[Q_RCV] > rcv_thr);
        set_vec[I_CMD_LOW] = (lvl_n[Q_CMD] < cmd_thr) && !(lvl_q[Q_CMD] < cmd_thr);
        set_vec[I_CMD_OVF] = ovf[Q_CMD];
        set_vec[I_RCV_OVF] = ovf[Q_RCV];
        set_vec[I_TTX_OVF] = ovf[Q_TTX];
    end

    qlw_irq_reg #(.W(NSTICKY)) u_irq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (set_vec),
        .clr_i  (irq_clr_i),
        .state_o(sticky)
    );

    assign irq_o = {full_o[Q_ACQ], sticky};

    a_r5_rcv_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_o[Q_RCV*LVL_W +: LVL_W] > LVL_W'(rcv_mark(rx_lvl_sel_i)))
        && ($past(level_o[Q_RCV*LVL_W +: LVL_W]) <= LVL_W'(rcv_mark(rx_lvl_sel_i)))
        && $stable(rx_lvl_sel_i) |-> irq_o[I_RCV_HI]);
    a_r6_cmd_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_o[Q_CMD*LVL_W +: LVL_W] < LVL_W'(cmd_mark(cmd_lvl_sel_i)))
        && ($past(level_o[Q_CMD*LVL_W +: LVL_W]) >= LVL_W'(cmd_mark(cmd_lvl_sel_i)))
        && $stable(cmd_lvl_sel_i) |-> irq_o[I_CMD_LOW]);
    a_r7_ovf_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i[Q_TTX] && full_o[Q_TTX] && !flush_i[Q_TTX]) |=> irq_o[I_TTX_OVF]);
    a_r8_acq_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(full_o[Q_ACQ]) |-> irq_o[5]);

endmodule

// File: tb/queue_watermark_irq_tb.sv
module queue_watermark_irq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int D  = 64;
    localparam int LW = 7;

    logic clk = 0;
    logic rst_n = 0;
    logic [3:0] push = 0, pop = 0, flush = 0;
    logic [2:0] rsel = 0;
    logic [1:0] csel = 0;
    logic [4:0] clr = 0;
    logic [4*LW-1:0] level;
    logic [3:0] full, empty;
    logic [5:0] irq;

    int checks = 0, errors = 0;
    int lvl [4];
    int sticky [5];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    queue_watermark_irq #(.DEPTH(D), .LVL_W(LW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .push_i(push), .pop_i(pop), .flush_i(flush),
        .rx_lvl_sel_i(rsel), .cmd_lvl_sel_i(csel), .irq_clr_i(clr),
        .level_o(level), .full_o(full), .empty_o(empty), .irq_o(irq));

    function automatic int rmark(int c);
        if (c == 0) return 1;
        if (c == 1) return 4;
        if (c == 2) return 8;
        if (c == 3) return 16;
        return 30;
    endfunction

    function automatic int cmark(int c);
        int t [4] = '{1, 4, 8, 16};
        return t[c];
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        for (int q = 0; q < 4; q++) begin
            chk($sformatf("R1 R3 level q%0d", q), int'(level[q*LW +: LW]), lvl[q]);
            chk($sformatf("R2 full q%0d", q), int'(full[q]), int'(lvl[q] == D));
            chk($sformatf("R2 empty q%0d", q), int'(empty[q]), int'(lvl[q] == 0));
        end
        chk("R6 R9 cmd low irq", int'(irq[0]), sticky[0]);
        chk("R4 R5 R9 rcv high irq", int'(irq[1]), sticky[1]);
        chk("R7 R9 cmd ovf irq", int'(irq[2]), sticky[2]);
        chk("R7 R9 rcv ovf irq", int'(irq[3]), sticky[3]);
        chk("R7 R9 ttx ovf irq", int'(irq[4]), sticky[4]);
        chk("R8 acq full irq", int'(irq[5]), int'(lvl[3] == D));
    endtask

    task automatic model_step();
        int nl [4];
        int set [5];
        for (int q = 0; q < 4; q++) begin
            if (flush[q]) nl[q] = 0;
            else nl[q] = lvl[q] + int'(push[q] && lvl[q] < D) - int'(pop[q] && lvl[q] > 0);
        end
        set[1] = int'(nl[1] > rmark(rsel) && !(lvl[1] > rmark(rsel)));
        set[0] = int'(nl[0] < cmark(csel) && !(lvl[0] < cmark(csel)));
        for (int q = 0; q < 3; q++) set[2+q] = int'(push[q] && lvl[q] == D && !flush[q]);
        for (int b = 0; b < 5; b++) sticky[b] = (clr[b] && !set[b]) ? 0 : (sticky[b] | set[b]);
        for (int q = 0; q < 4; q++) lvl[q] = nl[q];
    endtask

    initial begin
        for (int q = 0; q < 4; q++) lvl[q] = 0;
        for (int b = 0; b < 5; b++) sticky[b] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10 levels", int'(level), 0);
        chk("R10 empty", int'(empty), 15);
        chk("R10 full", int'(full), 0);
        chk("R10 irq", int'(irq), 0);
        rst_n = 1;
        for (int ph = 0; ph < 20; ph++) begin
            int up = (ph % 2 == 0) ? 80 : 20;
            rsel = 3'(ph % 8);
            csel = 2'(ph % 4);
            for (int c = 0; c < 250; c++) begin
                for (int q = 0; q < 4; q++) begin
                    push[q] = ($urandom % 100) < up;
                    pop[q]  = ($urandom % 100) < (100 - up);
                    flush[q] = ($urandom % 400) == 0;
                end
                for (int b = 0; b < 5; b++) clr[b] = ($urandom % 30) == 0;
                @(posedge clk);
                model_step();
                @(negedge clk);
                compare_all();
            end
        end
        push = 0; pop = 0; flush = 0; clr = 0;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule